// File: doc/BRIEF.md
# Bus Monitor with Address-Match Freeze

This block is an independent debug master on a shared 16-bit bus. It snoops every completed bus transaction, keeps the address and data of the most recent one from another master, and compares the address against a key value that an operator enters four bits at a time. When the comparator is enabled and a snooped address equals the key, the monitor raises a hold line to the bus arbiter. The arbiter then stops granting the bus to every other master, which freezes the system once the matching cycle has finished.

While the system is held, the operator can let other masters advance one bus cycle at a time. A step mode keeps the hold raised continuously, so that every cycle of the other masters needs its own step command. The monitor can also start its own single read or write to any memory or hardware-register address. That access uses the normal request/grant/strobe/acknowledge handshake and is not blocked by its own hold line. The monitor is meant to sit in the arbiter's slot just below memory refresh and above every other master. This lets a running processor's memory-mapped registers be read without stopping or reprogramming that processor.

An operator display port shows one 4-bit nibble at a time, taken from the key, the captured address, the captured data or the last read result.

Top module: `bus_freeze_monitor`

## Requirements
- R1: After reset, hold_o, frozen_o, mst_req_o, mst_stb_o and acc_done_o are 0, and the key, the captured address, the captured data and the read result are all 0.
- R2: A pulse on key_we_i writes key_nib_i into key bits [4*key_sel_i+3 : 4*key_sel_i] and leaves the other key bits unchanged.
- R3: A cycle with snp_vld_i high while the monitor is not driving mst_stb_o counts as another master's completed cycle. Its snp_addr_i and snp_data_i appear on cap_addr_o and cap_data_o from the next cycle on.
- R4: If match_en_i is high and the address of such a cycle equals the key, frozen_o and hold_o go high in the next cycle.
- R5: With match_en_i low, no address sets frozen_o, but capture (R3) continues.
- R6: When step_mode_i is high, hold_o is high from the next cycle on. A step_i pulse while held lowers hold_o from the next cycle until exactly one other-master cycle completes. hold_o is high again in the cycle after that cycle.
- R7: A release_i pulse clears frozen_o in the next cycle. Without step mode, hold_o goes low. With step mode high, the release also lets exactly one other-master cycle through, as a step does.
- R8: An acc_go_i pulse while idle raises mst_req_o in the next cycle. The cycle after mst_gnt_i is seen, mst_stb_o is driven with the latched address, write flag and write data. The cycle after mst_ack_i, acc_done_o pulses high for one cycle, mst_req_o and mst_stb_o fall, and the read data is latched.
- R9: A bus strobe seen while the monitor drives mst_stb_o is the monitor's own cycle. It neither changes the captured values nor freezes the system.
- R10: While busy, acc_go_i is ignored. The monitor's own access proceeds while hold_o is high.
- R11: disp_nib_o shows nibble disp_sel_i (bits [4*disp_sel_i+3 : 4*disp_sel_i]) of the source selected by disp_src_i: 0 = key, 1 = captured address, 2 = captured data, 3 = last read data.
- R12: A step_i pulse while neither frozen nor in step mode has no effect: hold_o stays low, including through the next other-master cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| snp_vld_i | input | 1 | A bus cycle completes this clock |
| snp_addr_i | input | 16 | Address of the completing bus cycle |
| snp_data_i | input | 16 | Data of the completing bus cycle |
| mst_req_o | output | 1 | Bus request of the monitor |
| mst_gnt_i | input | 1 | Bus grant to the monitor |
| mst_stb_o | output | 1 | Monitor drives its own bus cycle |
| mst_we_o | output | 1 | Own cycle is a write |
| mst_addr_o | output | 16 | Own cycle address |
| mst_wdata_o | output | 16 | Own cycle write data |
| mst_rdata_i | input | 16 | Read data returned to the monitor |
| mst_ack_i | input | 1 | Own cycle completes |
| hold_o | output | 1 | Arbiter must grant no other master |
| key_we_i | input | 1 | Write one key nibble |
| key_sel_i | input | 2 | Key nibble index |
| key_nib_i | input | 4 | Key nibble value |
| match_en_i | input | 1 | Address comparator enable |
| step_mode_i | input | 1 | Hold other masters and advance them by step |
| step_i | input | 1 | Let one other-master cycle through |
| release_i | input | 1 | Clear the freeze |
| acc_go_i | input | 1 | Start an own access |
| acc_we_i | input | 1 | Own access is a write |
| acc_addr_i | input | 16 | Own access address |
| acc_wdata_i | input | 16 | Own access write data |
| acc_busy_o | output | 1 | Own access in progress |
| acc_done_o | output | 1 | Own access finished (one-cycle pulse) |
| frozen_o | output | 1 | Address match has frozen the system |
| cap_addr_o | output | 16 | Last captured address |
| cap_data_o | output | 16 | Last captured data |
| disp_src_i | input | 2 | Display source select |
| disp_sel_i | input | 2 | Display nibble select |
| disp_nib_o | output | 4 | Displayed nibble |

## Verification
The checker watches every cycle for the step from a key hit to the freeze, for the lack of any freeze while the comparator is off, and for capture after each foreign strobe but never after the monitor's own strobe. It also checks the grant-to-strobe and acknowledge-to-done steps of the own access. How many foreign cycles get through after a step or a release in step mode depends on the order of commands and strobes, so only the bench's scenarios show it. The same holds for the exact nibble positions in key entry and display, and for step commands that should have no effect.

// File: rtl/bfm_pkg.sv
package bfm_pkg;
  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_REQ  = 2'd1,
    MS_XFER = 2'd2
  } mst_state_e;

  typedef enum logic [1:0] {
    DSP_KEY   = 2'd0,
    DSP_CADDR = 2'd1,
    DSP_CDATA = 2'd2,
    DSP_RDATA = 2'd3
  } disp_src_e;
endpackage

// File: rtl/bfm_key_reg.sv
module bfm_key_reg #(
  parameter int W     = 16,
  parameter int NIB_W = 4,
  localparam int NIBS = W / NIB_W,
  localparam int SELW = (NIBS > 1) ? $clog2(NIBS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SELW-1:0]  sel_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic [W-1:0]     key_o
);
  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    logic [NIB_W-1:0] nib_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            nib_q <= '0;
      else if (we_i && sel_i == SELW'(g))     nib_q <= nib_i;
    end
    assign key_o[g*NIB_W +: NIB_W] = nib_q;
  end
endmodule

// File: rtl/bfm_snoop.sv
module bfm_snoop #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic         own_i,
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] key_i,
  input  logic         en_i,
  output logic         other_o,
  output logic         hit_o,
  output logic [W-1:0] cap_addr_o,
  output logic [W-1:0] cap_data_o
);
  // own strobe on the bus is not a foreign cycle
  assign other_o = vld_i && !own_i;
  assign hit_o   = other_o && en_i && (addr_i == key_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_addr_o <= '0;
      cap_data_o <= '0;
    end else if (other_o) begin
      cap_addr_o <= addr_i;
      cap_data_o <= data_i;
    end
  end
endmodule

// File: rtl/bfm_hold_ctl.sv
module bfm_hold_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic other_i,
  input  logic hit_i,
  input  logic step_mode_i,
  input  logic step_i,
  input  logic release_i,
  output logic frozen_o,
  output logic hold_o
);
  logic frozen_q, frozen_d;
  logic mode_q;
  logic pass_q, pass_d;
  logic halted_q, pass_set;

  assign halted_q = frozen_q || mode_q;
  assign pass_set = (step_i && halted_q) || (release_i && frozen_q && mode_q);

  always_comb begin
    if (hit_i)          frozen_d = 1'b1;
    else if (release_i) frozen_d = 1'b0;
    else                frozen_d = frozen_q;

    if (pass_set)       pass_d = 1'b1;
    else if (other_i)   pass_d = 1'b0;
    else                pass_d = pass_q;
    // nothing to pass once the hold source is gone
    if (!frozen_d && !step_mode_i) pass_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frozen_q <= 1'b0;
      mode_q   <= 1'b0;
      pass_q   <= 1'b0;
    end else begin
      frozen_q <= frozen_d;
      mode_q   <= step_mode_i;
      pass_q   <= pass_d;
    end
  end

  assign frozen_o = frozen_q;
  assign hold_o   = halted_q && !pass_q;
endmodule

// File: rtl/bfm_master.sv
module bfm_master
  import bfm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic         we_i,
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         gnt_i,
  input  logic         ack_i,
  input  logic [W-1:0] rdata_i,
  output logic         req_o,
  output logic         stb_o,
  output logic         we_o,
  output logic [W-1:0] addr_o,
  output logic [W-1:0] wdata_o,
  output logic [W-1:0] rdata_o,
  output logic         busy_o,
  output logic         done_o
);
  mst_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MS_IDLE;
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
      rdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        MS_IDLE: if (go_i) begin
          state_q <= MS_REQ;
          we_o    <= we_i;
          addr_o  <= addr_i;
          wdata_o <= wdata_i;
        end
        MS_REQ: if (gnt_i) state_q <= MS_XFER;
        MS_XFER: if (ack_i) begin
          state_q <= MS_IDLE;
          done_o  <= 1'b1;
          if (!we_o) rdata_o <= rdata_i;
        end
        default: state_q <= MS_IDLE;
      endcase
    end
  end

  assign req_o  = (state_q == MS_REQ) || (state_q == MS_XFER);
  assign stb_o  = (state_q == MS_XFER);
  assign busy_o = (state_q != MS_IDLE);
endmodule

// File: rtl/bus_freeze_monitor.sv
module bus_freeze_monitor
  import bfm_pkg::*;
#(
  parameter int W     = 16,
  parameter int NIB_W = 4,
  localparam int NIBS = W / NIB_W,
  localparam int SELW = (NIBS > 1) ? $clog2(NIBS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             snp_vld_i,
  input  logic [W-1:0]     snp_addr_i,
  input  logic [W-1:0]     snp_data_i,
  output logic             mst_req_o,
  input  logic             mst_gnt_i,
  output logic             mst_stb_o,
  output logic             mst_we_o,
  output logic [W-1:0]     mst_addr_o,
  output logic [W-1:0]     mst_wdata_o,
  input  logic [W-1:0]     mst_rdata_i,
  input  logic             mst_ack_i,
  output logic             hold_o,
  input  logic             key_we_i,
  input  logic [SELW-1:0]  key_sel_i,
  input  logic [NIB_W-1:0] key_nib_i,
  input  logic             match_en_i,
  input  logic             step_mode_i,
  input  logic             step_i,
  input  logic             release_i,
  input  logic             acc_go_i,
  input  logic             acc_we_i,
  input  logic [W-1:0]     acc_addr_i,
  input  logic [W-1:0]     acc_wdata_i,
  output logic             acc_busy_o,
  output logic             acc_done_o,
  output logic             frozen_o,
  output logic [W-1:0]     cap_addr_o,
  output logic [W-1:0]     cap_data_o,
  input  logic [1:0]       disp_src_i,
  input  logic [SELW-1:0]  disp_sel_i,
  output logic [NIB_W-1:0] disp_nib_o
);
  logic [W-1:0] key_q;
  logic [W-1:0] rdata_q;
  logic         other, hit;
  logic [W-1:0] disp_word;

  bfm_key_reg #(.W(W), .NIB_W(NIB_W)) u_key (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (key_we_i),
    .sel_i  (key_sel_i),
    .nib_i  (key_nib_i),
    .key_o  (key_q)
  );

  bfm_snoop #(.W(W)) u_snoop (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vld_i      (snp_vld_i),
    .own_i      (mst_stb_o),
    .addr_i     (snp_addr_i),
    .data_i     (snp_data_i),
    .key_i      (key_q),
    .en_i       (match_en_i),
    .other_o    (other),
    .hit_o      (hit),
    .cap_addr_o (cap_addr_o),
    .cap_data_o (cap_data_o)
  );

  bfm_hold_ctl u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .other_i     (other),
    .hit_i       (hit),
    .step_mode_i (step_mode_i),
    .step_i      (step_i),
    .release_i   (release_i),
    .frozen_o    (frozen_o),
    .hold_o      (hold_o)
  );

  bfm_master #(.W(W)) u_mst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (acc_go_i),
    .we_i    (acc_we_i),
    .addr_i  (acc_addr_i),
    .wdata_i (acc_wdata_i),
    .gnt_i   (mst_gnt_i),
    .ack_i   (mst_ack_i),
    .rdata_i (mst_rdata_i),
    .req_o   (mst_req_o),
    .stb_o   (mst_stb_o),
    .we_o    (mst_we_o),
    .addr_o  (mst_addr_o),
    .wdata_o (mst_wdata_o),
    .rdata_o (rdata_q),
    .busy_o  (acc_busy_o),
    .done_o  (acc_done_o)
  );

  always_comb begin
    unique case (disp_src_e'(disp_src_i))
      DSP_KEY:   disp_word = key_q;
      DSP_CADDR: disp_word = cap_addr_o;
      DSP_CDATA: disp_word = cap_data_o;
      default:   disp_word = rdata_q;
    endcase
  end

  assign disp_nib_o = disp_word[disp_sel_i*NIB_W +: NIB_W];
endmodule

// File: rtl/bfm_checker.sv
module bfm_checker #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         snp_vld_i,
  input logic [W-1:0] snp_addr_i,
  input logic [W-1:0] key_q,
  input logic         match_en_i,
  input logic         frozen_o,
  input logic [W-1:0] cap_addr_o,
  input logic         mst_req_o,
  input logic         mst_gnt_i,
  input logic         mst_stb_o,
  input logic         mst_ack_i,
  input logic         acc_done_o
);
  assert_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_vld_i && !mst_stb_o |=> cap_addr_o == $past(snp_addr_i));

  assert_hit_freezes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_vld_i && !mst_stb_o && match_en_i && snp_addr_i == key_q |=> frozen_o);

  assert_no_match_when_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frozen_o && !match_en_i |=> !frozen_o);

  assert_grant_to_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_req_o && mst_gnt_i && !mst_stb_o |=> mst_stb_o);

  assert_ack_to_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_stb_o && mst_ack_i |=> acc_done_o && !mst_stb_o);

  assert_own_not_captured_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_stb_o && snp_vld_i |=> $stable(cap_addr_o));
endmodule

bind bus_freeze_monitor bfm_checker #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .snp_vld_i  (snp_vld_i),
  .snp_addr_i (snp_addr_i),
  .key_q      (key_q),
  .match_en_i (match_en_i),
  .frozen_o   (frozen_o),
  .cap_addr_o (cap_addr_o),
  .mst_req_o  (mst_req_o),
  .mst_gnt_i  (mst_gnt_i),
  .mst_stb_o  (mst_stb_o),
  .mst_ack_i  (mst_ack_i),
  .acc_done_o (acc_done_o)
);

// File: tb/bus_freeze_monitor_test.sv
module bus_freeze_monitor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        snp_vld = 0;
  logic [15:0] snp_addr = 0, snp_data = 0;
  logic        mst_req, mst_gnt = 0, mst_stb, mst_we, mst_ack = 0;
  logic [15:0] mst_addr, mst_wdata, mst_rdata = 0;
  logic        hold;
  logic        key_we = 0;
  logic [1:0]  key_sel = 0;
  logic [3:0]  key_nib = 0;
  logic        match_en = 0, step_mode = 0, step = 0, rel = 0;
  logic        acc_go = 0, acc_we = 0;
  logic [15:0] acc_addr = 0, acc_wdata = 0;
  logic        acc_busy, acc_done, frozen;
  logic [15:0] cap_addr, cap_data;
  logic [1:0]  disp_src = 0, disp_sel = 0;
  logic [3:0]  disp_nib;

  int n_tests = 0;
  int n_fail  = 0;

  bus_freeze_monitor uut (
    .clk_i(clk), .rst_ni(rst_n),
    .snp_vld_i(snp_vld), .snp_addr_i(snp_addr), .snp_data_i(snp_data),
    .mst_req_o(mst_req), .mst_gnt_i(mst_gnt), .mst_stb_o(mst_stb), .mst_we_o(mst_we),
    .mst_addr_o(mst_addr), .mst_wdata_o(mst_wdata), .mst_rdata_i(mst_rdata), .mst_ack_i(mst_ack),
    .hold_o(hold),
    .key_we_i(key_we), .key_sel_i(key_sel), .key_nib_i(key_nib),
    .match_en_i(match_en), .step_mode_i(step_mode), .step_i(step), .release_i(rel),
    .acc_go_i(acc_go), .acc_we_i(acc_we), .acc_addr_i(acc_addr), .acc_wdata_i(acc_wdata),
    .acc_busy_o(acc_busy), .acc_done_o(acc_done),
    .frozen_o(frozen), .cap_addr_o(cap_addr), .cap_data_o(cap_data),
    .disp_src_i(disp_src), .disp_sel_i(disp_sel), .disp_nib_o(disp_nib)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic snoop(input logic [15:0] a, input logic [15:0] d);
    snp_vld = 1; snp_addr = a; snp_data = d;
    tick();
    snp_vld = 0;
  endtask

  task automatic set_nib(input int sel, input logic [3:0] v);
    key_we = 1; key_sel = 2'(sel); key_nib = v;
    tick();
    key_we = 0;
  endtask

  task automatic pulse_step();
    step = 1; tick(); step = 0;
  endtask

  task automatic pulse_rel();
    rel = 1; tick(); rel = 0;
  endtask

  task automatic show(input int src, input int sel);
    disp_src = 2'(src); disp_sel = 2'(sel);
    #1;
  endtask

  // {match_en, addr, data, expect_frozen}
  localparam logic [33:0] VEC [6] = '{
    {1'b1, 16'h1234, 16'hAAAA, 1'b0},
    {1'b1, 16'hC102, 16'h5555, 1'b1},
    {1'b0, 16'hC102, 16'h0101, 1'b0},
    {1'b1, 16'hC103, 16'h7777, 1'b0},
    {1'b1, 16'h0102, 16'h0001, 1'b0},
    {1'b1, 16'hC102, 16'hFFFF, 1'b1}
  };

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tick(); tick();
    // R1 reset state
    chk("R1 hold", hold, 0);
    chk("R1 frozen", frozen, 0);
    chk("R1 req", mst_req, 0);
    chk("R1 stb", mst_stb, 0);
    chk("R1 cap_addr", cap_addr, 0);
    show(0, 3);
    chk("R1 key", disp_nib, 0);
    rst_n = 1;
    tick();

    // R2 key entry nibble by nibble, R11 display of key
    set_nib(3, 4'hC); set_nib(2, 4'h1); set_nib(1, 4'h0); set_nib(0, 4'h2);
    show(0, 3); chk("R2 R11 nib3", disp_nib, 4'hC);
    show(0, 2); chk("R2 R11 nib2", disp_nib, 4'h1);
    show(0, 0); chk("R2 R11 nib0", disp_nib, 4'h2);
    set_nib(1, 4'hF);
    show(0, 1); chk("R2 overwrite nib1", disp_nib, 4'hF);
    show(0, 3); chk("R2 others kept", disp_nib, 4'hC);
    set_nib(1, 4'h0);

    // R3 R4 R5 vector walk, key = C102
    for (int i = 0; i < 6; i++) begin
      match_en = VEC[i][33];
      snoop(VEC[i][32:17], VEC[i][16:1]);
      chk("R3 cap addr", cap_addr, VEC[i][32:17]);
      chk("R3 cap data", cap_data, VEC[i][16:1]);
      chk("R4 R5 frozen", frozen, VEC[i][0]);
      chk("R4 hold", hold, VEC[i][0]);
      if (VEC[i][0]) begin
        pulse_rel();
        chk("R7 release frozen", frozen, 0);
        chk("R7 release hold", hold, 0);
      end
    end
    show(1, 3); chk("R11 cap addr nib3", disp_nib, 4'hC);
    show(2, 1); chk("R11 cap data nib1", disp_nib, 4'hF);
    match_en = 0;

    // R6 step mode
    step_mode = 1; tick();
    chk("R6 hold in step mode", hold, 1);
    pulse_step();
    chk("R6 hold open after step", hold, 0);
    snoop(16'h2000, 16'h0042);
    chk("R6 hold back after one", hold, 1);
    chk("R6 stepped cycle captured", cap_addr, 16'h2000);
    snoop(16'h2002, 16'h0043);
    chk("R6 no step no capture change", hold, 1);
    step_mode = 0; tick();
    chk("R6 step mode off", hold, 0);

    // R12 step while running
    pulse_step();
    chk("R12 hold low", hold, 0);
    snoop(16'h3000, 16'h0);
    chk("R12 hold still low", hold, 0);

    // step while frozen, R7 release in step mode
    match_en = 1;
    snoop(16'hC102, 16'h1111);
    chk("R4 frozen again", frozen, 1);
    pulse_step();
    chk("R6 step while frozen", hold, 0);
    chk("R6 frozen kept", frozen, 1);
    snoop(16'h4000, 16'h0);
    chk("R6 rehold after step", hold, 1);
    step_mode = 1; tick();
    pulse_rel();
    chk("R7 release clears freeze", frozen, 0);
    chk("R7 release opens one", hold, 0);
    snoop(16'h4002, 16'h0);
    chk("R7 rehold in step mode", hold, 1);
    step_mode = 0; tick();
    chk("R7 run", hold, 0);

    // R8 R9 R10 own read while frozen
    snoop(16'hC102, 16'h2222);
    chk("R10 frozen before access", hold, 1);
    acc_go = 1; acc_we = 0; acc_addr = 16'h7010; tick();
    chk("R8 req", mst_req, 1);
    chk("R8 no stb yet", mst_stb, 0);
    acc_go = 1; acc_addr = 16'h1111; mst_gnt = 1; tick();
    acc_go = 0; mst_gnt = 0;
    chk("R8 stb", mst_stb, 1);
    chk("R10 go ignored while busy", mst_addr, 16'h7010);
    chk("R8 read", mst_we, 0);
    chk("R10 busy", acc_busy, 1);
    snp_vld = 1; snp_addr = 16'h7010; snp_data = 16'hBEEF;
    mst_ack = 1; mst_rdata = 16'hBEEF; tick();
    snp_vld = 0; mst_ack = 0;
    chk("R8 done", acc_done, 1);
    chk("R8 stb low", mst_stb, 0);
    chk("R8 req low", mst_req, 0);
    chk("R9 own not captured", cap_addr, 16'hC102);
    chk("R9 frozen kept", frozen, 1);
    show(3, 3); chk("R11 rdata nib3", disp_nib, 4'hB);
    show(3, 0); chk("R11 rdata nib0", disp_nib, 4'hF);
    tick();
    chk("R8 done one cycle", acc_done, 0);

    // own write
    acc_go = 1; acc_we = 1; acc_addr = 16'h7020; acc_wdata = 16'h5A5A; tick();
    acc_go = 0; mst_gnt = 1; tick();
    mst_gnt = 0;
    chk("R8 write flag", mst_we, 1);
    chk("R8 wdata", mst_wdata, 16'h5A5A);
    mst_ack = 1; tick(); mst_ack = 0;
    chk("R8 write done", acc_done, 1);
    pulse_rel();
    chk("R7 final release", hold, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule